// File: doc/BRIEF.md
# Flash Quad-Enable Initialization Sequencer

This block performs the one-time bring-up step that switches a serial NOR flash into four-line read mode. After reset it waits for a `start` pulse. It then checks two capability inputs: one says the host controller can receive on four lines, and the other says the attached device has a quad-enable bit. If either one is low, the block finishes at once without touching the bus. If both are high, it programs the device's quad-enable bit over a single-line SPI port and reads the bit back to confirm it. At the end it reports `done` together with either `quad_ok` or `error`.

A vendor code picks one of two register layouts. On layout A the enable bit sits in the status register. The block reads that register, sets the bit, writes the register back, polls until the write completes, and reads the status register again. On layout B the enable bit sits in a second configuration register. The block writes the status and configuration bytes together and then reads the configuration register back. Every register write is preceded by a write-enable command. Every command is a separate chip-select frame, sent MSB first in SPI mode 0 with `sclk` at half the core clock.

The controller moves through these states. ST_IDLE goes to ST_RD_OP (layout A), to ST_WEN (layout B), or to ST_DONE (no capability). ST_RD_OP goes to ST_RD_DAT and then to ST_WEN. ST_WEN goes to ST_WR_OP and then to ST_WR_B1. From ST_WR_B1, layout A goes to ST_POLL_OP and layout B goes to ST_WR_B2 and then to ST_VFY_OP. ST_POLL_OP goes to ST_POLL_DAT. From ST_POLL_DAT the controller returns to ST_POLL_OP while the device is busy, goes to ST_VFY_OP once it is ready, or goes to ST_DONE when the timeout expires. ST_VFY_OP goes to ST_VFY_DAT and then to ST_DONE. ST_DONE is terminal. Each byte state advances when the byte engine reports that the byte is complete.

Top module: `qe_init_seq`

## Requirements
- R1: When `start` is pulsed while `host_quad` or `dev_quad` is low, `done` rises on the next clock edge with `quad_ok` and `error` both low, and `cs_n` never goes low.
- R2: Layout A is used only when `vendor_id` equals `VENDOR_A_CODE`; every other value, including codes that differ in a single bit, uses layout B.
- R3: On layout A the block first sends a status read frame (opcode 0x05, one response byte) and later a status write frame (opcode 0x01) whose data byte is the value read with bit 6 (0x40) set.
- R4: On both layouts a one-byte write-enable frame (opcode 0x06) is sent immediately before the register write frame.
- R5: On layout A, after the write, the block repeats status read frames (0x05) while bit 0 of the returned byte is 1. Once bit 0 is 0, it sends one more 0x05 frame, and it sets `error` if bit 6 of that response is 0.
- R6: On layout A, if `POLL_LIMIT` successive poll responses all have bit 0 set, the block stops after the last of them and reports `done` with `error` high.
- R7: On layout B the block sends the three-byte frame 0x01, 0x00, 0x02 and then a read frame with opcode 0x35, and it sets `error` if bit 1 of that response is 0.
- R8: On success `done` and `quad_ok` rise together. On failure `done` and `error` rise together with `quad_ok` low. Whichever outcome occurs holds unchanged until reset.
- R9: Once `done` is high, further `start` pulses start no bus activity.
- R10: Each command is its own frame with `cs_n` low. Bytes go MSB first in SPI mode 0, `sclk` is low whenever `cs_n` is high, and the dummy transmit byte during a read response is 0x00.
- R11: After reset `cs_n` is high, `sclk` is low, and `done`, `quad_ok` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| host_quad | input | 1 | Host can receive on four lines |
| dev_quad | input | 1 | Device has a quad-enable bit |
| vendor_id | input | VID_W | Vendor code that selects the register layout |
| sclk | output | 1 | SPI serial clock (mode 0) |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| done | output | 1 | Sequence finished (sticky) |
| quad_ok | output | 1 | Quad-enable bit confirmed (sticky) |
| error | output | 1 | Read-back or timeout failure (sticky) |

## Verification
The bench builds the block with `POLL_LIMIT` set to 4, so the timeout path on layout A is reached after four busy polls instead of a thousand. It sets `VENDOR_A_CODE` to 0x5A, so a neighbouring code such as 0x5B exercises the rule that every other vendor code goes to layout B. A behavioural flash model can hold its busy bit for a chosen number of polls or indefinitely. It can also refuse to latch the enable bit, which brings both read-back failure paths within reach.

// File: rtl/qe_pkg.sv
package qe_pkg;

    typedef logic [7:0] qe_byte_t;

    localparam qe_byte_t OP_WREN = 8'h06;
    localparam qe_byte_t OP_RDSR = 8'h05;
    localparam qe_byte_t OP_WRSR = 8'h01;
    localparam qe_byte_t OP_RDCR = 8'h35;
    localparam qe_byte_t MASK_A  = 8'h40;
    localparam qe_byte_t MASK_B  = 8'h02;
    localparam qe_byte_t DUMMY   = 8'h00;
    localparam int       BUSY_BIT = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_OP,
        ST_RD_DAT,
        ST_WEN,
        ST_WR_OP,
        ST_WR_B1,
        ST_WR_B2,
        ST_POLL_OP,
        ST_POLL_DAT,
        ST_VFY_OP,
        ST_VFY_DAT,
        ST_DONE
    } qe_state_e;

endpackage

// File: rtl/qe_spi_byte.sv
module qe_spi_byte #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [BYTE_W-1:0] tx,
    input  logic              last,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef enum logic {EN_IDLE, EN_SHIFT} eng_e;

    eng_e              st;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] rx_q;
    logic [CNT_W-1:0]  bit_q;
    logic              last_q;
    logic              sclk_q;
    logic              cs_q;

    assign mosi      = sh_q[BYTE_W-1];
    assign sclk      = sclk_q;
    assign cs_n      = cs_q;
    assign rx        = rx_q;
    assign byte_done = (st == EN_SHIFT) && sclk_q && (bit_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= EN_IDLE;
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            last_q <= 1'b0;
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            unique case (st)
                EN_IDLE: begin
                    if (req) begin
                        cs_q   <= 1'b0;
                        sh_q   <= tx;
                        last_q <= last;
                        bit_q  <= CNT_W'(BYTE_W - 1);
                        st     <= EN_SHIFT;
                    end
                end
                EN_SHIFT: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[BYTE_W-2:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == '0) begin
                            st <= EN_IDLE;
                            if (last_q) cs_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q - 1'b1;
                            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/qe_poll_timer.sv
module qe_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/qe_ctrl.sv
module qe_ctrl
    import qe_pkg::*;
#(
    parameter int               VID_W         = 8,
    parameter logic [VID_W-1:0] VENDOR_A_CODE = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             host_quad,
    input  logic             dev_quad,
    input  logic [VID_W-1:0] vendor_id,
    output logic             eng_req,
    output qe_byte_t         eng_tx,
    output logic             eng_last,
    input  logic             eng_done,
    input  qe_byte_t         eng_rx,
    output logic             tmr_clr,
    output logic             tmr_tick,
    input  logic             tmr_last,
    output logic             done,
    output logic             quad_ok,
    output logic             error
);
    qe_state_e state, nxt;
    logic      path_a_q;
    qe_byte_t  sr_q;
    logic      caps;
    logic      busy;

    assign caps = host_quad && dev_quad;
    assign busy = eng_rx[BUSY_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = !caps ? ST_DONE
                                         : (vendor_id == VENDOR_A_CODE) ? ST_RD_OP : ST_WEN;
            ST_RD_OP:    if (eng_done) nxt = ST_RD_DAT;
            ST_RD_DAT:   if (eng_done) nxt = ST_WEN;
            ST_WEN:      if (eng_done) nxt = ST_WR_OP;
            ST_WR_OP:    if (eng_done) nxt = ST_WR_B1;
            ST_WR_B1:    if (eng_done) nxt = path_a_q ? ST_POLL_OP : ST_WR_B2;
            ST_WR_B2:    if (eng_done) nxt = ST_VFY_OP;
            ST_POLL_OP:  if (eng_done) nxt = ST_POLL_DAT;
            ST_POLL_DAT: if (eng_done) nxt = !busy ? ST_VFY_OP
                                           : tmr_last ? ST_DONE : ST_POLL_OP;
            ST_VFY_OP:   if (eng_done) nxt = ST_VFY_DAT;
            ST_VFY_DAT:  if (eng_done) nxt = ST_DONE;
            ST_DONE:     nxt = ST_DONE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        eng_req  = (state != ST_IDLE) && (state != ST_DONE);
        eng_tx   = DUMMY;
        eng_last = 1'b0;
        unique case (state)
            ST_RD_OP:    eng_tx = OP_RDSR;
            ST_RD_DAT:   eng_last = 1'b1;
            ST_WEN:      begin eng_tx = OP_WREN; eng_last = 1'b1; end
            ST_WR_OP:    eng_tx = OP_WRSR;
            ST_WR_B1:    begin eng_tx = path_a_q ? (sr_q | MASK_A) : DUMMY; eng_last = path_a_q; end
            ST_WR_B2:    begin eng_tx = MASK_B; eng_last = 1'b1; end
            ST_POLL_OP:  eng_tx = OP_RDSR;
            ST_POLL_DAT: eng_last = 1'b1;
            ST_VFY_OP:   eng_tx = path_a_q ? OP_RDSR : OP_RDCR;
            ST_VFY_DAT:  eng_last = 1'b1;
            default:     ;
        endcase
        tmr_clr  = (state == ST_IDLE);
        tmr_tick = (state == ST_POLL_DAT) && eng_done && busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            quad_ok  <= 1'b0;
            error    <= 1'b0;
            path_a_q <= 1'b0;
            sr_q     <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                path_a_q <= (vendor_id == VENDOR_A_CODE);
                if (!caps) done <= 1'b1;
            end
            if (state == ST_RD_DAT && eng_done) sr_q <= eng_rx;
            if (state == ST_POLL_DAT && eng_done && busy && tmr_last) begin
                done  <= 1'b1;
                error <= 1'b1;
            end
            if (state == ST_VFY_DAT && eng_done) begin
                done <= 1'b1;
                if ((eng_rx & (path_a_q ? MASK_A : MASK_B)) != '0) quad_ok <= 1'b1;
                else                                               error   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/qe_init_seq.sv
module qe_init_seq
    import qe_pkg::*;
#(
    parameter int               VID_W         = 8,
    parameter logic [VID_W-1:0] VENDOR_A_CODE = 8'h5A,
    parameter int               POLL_LIMIT    = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             host_quad,
    input  logic             dev_quad,
    input  logic [VID_W-1:0] vendor_id,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             done,
    output logic             quad_ok,
    output logic             error
);
    localparam int BYTE_W = $bits(qe_byte_t);

    logic     eng_req, eng_last, eng_done;
    qe_byte_t eng_tx, eng_rx;
    logic     tmr_clr, tmr_tick, tmr_last;

    qe_ctrl #(.VID_W(VID_W), .VENDOR_A_CODE(VENDOR_A_CODE)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .host_quad(host_quad),
        .dev_quad(dev_quad), .vendor_id(vendor_id),
        .eng_req(eng_req), .eng_tx(eng_tx), .eng_last(eng_last),
        .eng_done(eng_done), .eng_rx(eng_rx),
        .tmr_clr(tmr_clr), .tmr_tick(tmr_tick), .tmr_last(tmr_last),
        .done(done), .quad_ok(quad_ok), .error(error)
    );

    qe_spi_byte #(.BYTE_W(BYTE_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .req(eng_req), .tx(eng_tx), .last(eng_last),
        .byte_done(eng_done), .rx(eng_rx),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    qe_poll_timer #(.LIMIT(POLL_LIMIT)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tmr_tick), .last(tmr_last)
    );
endmodule

// File: rtl/qe_init_seq_chk.sv
module qe_init_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic done,
    input logic quad_ok,
    input logic error
);
    AST_OUTCOME_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(quad_ok && error));        // R8
    AST_QOK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) quad_ok |-> done);           // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) error |-> done);             // R8
    AST_RESULT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                           done |=> done && $stable(quad_ok) && $stable(error));                         // R8
    AST_BUS_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n);              // R9
    AST_SCLK_PARKED:   assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);             // R10
endmodule

bind qe_init_seq qe_init_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .done(done), .quad_ok(quad_ok), .error(error)
);

// File: tb/qe_init_seq_tb_top.sv
`timescale 1ns/1ps
module qe_init_seq_tb_top;
    localparam logic [7:0] VA = 8'h5A;
    localparam int         PL = 4;

    logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic       host_quad = 1'b0, dev_quad = 1'b0, miso = 1'b0;
    logic [7:0] vendor_id = 8'h00;
    wire        sclk, cs_n, mosi, done, quad_ok, error;

    int n_chk = 0, n_fail = 0, frames_seen = 0;
    string cur_req = "R10";

    typedef struct packed { logic [2:0] n; logic [31:0] d; } frame_t;
    frame_t exp_q[$];

    // flash model state
    logic [7:0]  m_sr = 8'h00, m_cr = 8'h00, m_cur = 8'h00, m_resp = 8'h00;
    logic [31:0] m_fr = '0;
    int          m_bit = 0, m_nb = 0, m_busy = 0, m_busy_cfg = 0;
    bit          m_wel = 0, m_hang = 0, m_hang_cfg = 0, m_stuck = 0;

    always #2 clk = ~clk;

    qe_init_seq #(.VID_W(8), .VENDOR_A_CODE(VA), .POLL_LIMIT(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .host_quad(host_quad),
        .dev_quad(dev_quad), .vendor_id(vendor_id), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .done(done), .quad_ok(quad_ok), .error(error)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int n, input logic [31:0] d);
        frame_t f;
        f.n = 3'(n);
        f.d = d;
        exp_q.push_back(f);
    endtask

    // serial side of the flash model: sample on rising, drive on falling
    always @(sclk) begin
        if (cs_n === 1'b0) begin
            if (sclk) begin
                m_cur = {m_cur[6:0], mosi};
                m_bit++;
                if (m_bit == 8) begin
                    m_bit = 0;
                    if (m_nb < 4) m_fr[31-8*m_nb -: 8] = m_cur;
                    if (m_nb == 0)
                        m_resp = (m_cur == 8'h05) ? (m_sr | {7'd0, (m_busy > 0) || m_hang})
                               : (m_cur == 8'h35) ? m_cr : 8'h00;
                    m_nb++;
                end
            end else begin
                miso   = m_resp[7];
                m_resp = {m_resp[6:0], 1'b0};
            end
        end
    end

    // frame end: model update and scoreboard monitor
    always @(posedge cs_n) begin
        if (m_nb > 0) begin
            frames_seen++;
            case (m_fr[31:24])
                8'h06: m_wel = 1;
                8'h01: if (m_wel) begin
                    if (m_nb >= 2) m_sr = m_fr[23:16] & (m_stuck ? 8'hBF : 8'hFF);
                    if (m_nb >= 3) m_cr = m_fr[15:8]  & (m_stuck ? 8'hFD : 8'hFF);
                    m_busy = m_busy_cfg;
                    m_hang = m_hang_cfg;
                    m_wel  = 0;
                end
                8'h05: if (m_nb >= 2 && m_busy > 0) m_busy--;
                default: ;
            endcase
            if (exp_q.size() == 0) begin
                chk(0, cur_req, "unexpected frame", {29'd0, 3'(m_nb), m_fr}, 64'd0);
            end else begin
                frame_t e;
                e = exp_q.pop_front();
                chk(e.n == 3'(m_nb) && e.d == m_fr, cur_req, "frame",
                    {29'd0, 3'(m_nb), m_fr}, {29'd0, e});
            end
            m_nb  = 0;
            m_bit = 0;
            m_fr  = '0;
        end
    end

    task automatic reset_dut();
        rst_n = 1'b0;
        start = 1'b0;
        exp_q.delete();
        m_sr = 8'h00; m_cr = 8'h00; m_busy = 0; m_busy_cfg = 0;
        m_hang = 0; m_hang_cfg = 0; m_stuck = 0; m_wel = 0;
        m_nb = 0; m_bit = 0; m_fr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int i;
        for (i = 0; i < 3000 && !done; i++) @(negedge clk);
        chk(done === 1'b1, req, "done reached", 64'(done), 64'd1);
    endtask

    task automatic check_result(input string req, input bit ok_exp, input bit err_exp);
        chk(quad_ok === ok_exp, req, "quad_ok", 64'(quad_ok), 64'(ok_exp));
        chk(error === err_exp, req, "error", 64'(error), 64'(err_exp));
        chk(exp_q.size() == 0, req, "frames left", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        // R11 reset state
        reset_dut();
        chk(cs_n === 1'b1, "R11", "cs_n", 64'(cs_n), 64'd1);
        chk(sclk === 1'b0, "R11", "sclk", 64'(sclk), 64'd0);
        chk({done, quad_ok, error} === 3'b000, "R11", "flags", 64'({done, quad_ok, error}), 64'd0);

        // R1 host lacks quad
        host_quad = 0; dev_quad = 1; vendor_id = VA; cur_req = "R1";
        base = frames_seen;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done === 1'b1, "R1", "done next edge", 64'(done), 64'd1);
        check_result("R1", 0, 0);
        repeat (10) @(negedge clk);
        chk(frames_seen == base, "R1", "bus frames", 64'(frames_seen - base), 64'd0);

        // R1 device lacks quad
        reset_dut();
        host_quad = 1; dev_quad = 0; base = frames_seen;
        pulse_start();
        wait_done("R1");
        check_result("R1", 0, 0);
        chk(frames_seen == base, "R1", "bus frames dev", 64'(frames_seen - base), 64'd0);

        // R3 R4 R5 layout A success with two busy polls
        reset_dut();
        host_quad = 1; dev_quad = 1; vendor_id = VA; cur_req = "R3";
        m_sr = 8'h1C; m_busy_cfg = 2;
        push(2, 32'h0500_0000);
        push(1, 32'h0600_0000);
        push(2, 32'h015C_0000);
        for (int k = 0; k < 3; k++) push(2, 32'h0500_0000);
        push(2, 32'h0500_0000);
        pulse_start();
        wait_done("R5");
        check_result("R5", 1, 0);
        chk(m_sr == 8'h5C, "R3", "status after write", 64'(m_sr), 64'h5C);
        repeat (20) @(negedge clk);
        chk(quad_ok === 1'b1, "R8", "quad_ok held", 64'(quad_ok), 64'd1);
        // R9 restart ignored
        base = frames_seen; cur_req = "R9";
        pulse_start();
        repeat (60) @(negedge clk);
        chk(frames_seen == base, "R9", "frames after done", 64'(frames_seen - base), 64'd0);
        chk(done === 1'b1 && quad_ok === 1'b1, "R9", "result kept", 64'({done, quad_ok}), 64'd3);

        // R5 layout A, device refuses the bit
        reset_dut();
        vendor_id = VA; cur_req = "R5"; m_stuck = 1;
        push(2, 32'h0500_0000);
        push(1, 32'h0600_0000);
        push(2, 32'h0140_0000);
        push(2, 32'h0500_0000);
        push(2, 32'h0500_0000);
        pulse_start();
        wait_done("R5");
        check_result("R5", 0, 1);

        // R6 layout A, busy never clears
        reset_dut();
        vendor_id = VA; cur_req = "R6"; m_sr = 8'h1C; m_hang_cfg = 1;
        push(2, 32'h0500_0000);
        push(1, 32'h0600_0000);
        push(2, 32'h015C_0000);
        for (int k = 0; k < PL; k++) push(2, 32'h0500_0000);
        pulse_start();
        wait_done("R6");
        check_result("R6", 0, 1);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && cs_n === 1'b1, "R6", "no further polls", 64'(exp_q.size()), 64'd0);

        // R2 R7 layout B via neighbouring code
        reset_dut();
        vendor_id = VA ^ 8'h01; cur_req = "R7"; m_sr = 8'h1C;
        push(1, 32'h0600_0000);
        push(3, 32'h0100_0200);
        push(2, 32'h3500_0000);
        pulse_start();
        wait_done("R7");
        check_result("R2", 1, 0);
        chk(m_cr == 8'h02, "R7", "config after write", 64'(m_cr), 64'h02);

        // R7 layout B, device refuses the bit
        reset_dut();
        vendor_id = 8'h00; cur_req = "R7"; m_stuck = 1;
        push(1, 32'h0600_0000);
        push(3, 32'h0100_0200);
        push(2, 32'h3500_0000);
        pulse_start();
        wait_done("R7");
        check_result("R7", 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule